// File: doc/BRIEF.md
# Reset-Aware External Bus Gate

This block decides who may use the external memory bus and when, across two kinds of reset. A power-on reset clears everything. It forces every grant and the bus driver enable off at once, and it restarts a hidden startup counter. External accesses stay blocked until that counter has counted 127 bus clocks. A manual reset is handled more gently. The beat in flight finishes, any remaining beats of a burst are dropped, and the block parks in an access-wait state. In that state it still serves refresh requests from the refresh timer, but it turns away external bus-request arbitration.

Three requesters compete for the bus: an internal access port (single beat or four-beat burst), a refresh request, and an external bus master. Each grant stays asserted until its requester drops its request. A small control register sets the number of wait cycles in each access beat. Only power-on reset loads that register; a manual reset leaves it as it is.

Top module: `busResetGate`

## Requirements
- R1: While `porN` is low, `accGnt`, `refGnt`, `busAck`, `beatStb` and `busOe` are 0. This takes effect without waiting for a clock edge, even in the middle of an access.
- R2: Power-on reset loads the control register with 0x02. A manual reset does not change it. `regWe` writes `regWdata` on a clock edge, and `regRdata` always shows the current value.
- R3: After a power-on reset, no access is granted until the hidden startup counter reaches 127. If `accReq` is held high from the release of `porN`, `accGnt` rises after the 130th rising clock edge and not before.
- R4: A manual reset does not clear the startup counter. If `manRstN` is released at the same time as `accReq` is raised, `accGnt` is still 0 after the third edge and is 1 after the fourth.
- R5: An access beat lasts waitSel+1 clock cycles, where waitSel is control register bits [2:0], sampled when the access starts. `accBurst`=0 gives 1 beat and `accBurst`=1 gives 4 beats. `busOe` is high for exactly the beat cycles, and `beatStb` is high in the last cycle of each beat.
- R6: After its beats, `accGnt` stays high as long as `accReq` stays high. It falls on the first edge after `accReq` goes low.
- R7: When a manual reset reaches the block during an access, the beat in progress completes and the remaining beats are dropped. `accGnt` and `busOe` then stay low for as long as the manual reset lasts, even if `accReq` is high.
- R8: While manual reset is asserted, a refresh request is still granted on `refGnt`.
- R9: While manual reset is asserted, `extReq` is never acknowledged. Outside manual reset, `extReq` is acknowledged on `busAck` when the bus is idle, and `busOe` is 0 while `busAck` is high.
- R10: When requests arrive together, refresh wins over access, and access wins over the external master. At most one of `accGnt`, `refGnt` and `busAck` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| porN | input | 1 | Power-on reset, active low, asynchronous assert |
| manRstN | input | 1 | Manual reset, active low, synchronized inside |
| accReq | input | 1 | Internal access request |
| accBurst | input | 1 | 1 = four-beat burst, 0 = single beat |
| accGnt | output | 1 | Access grant |
| beatStb | output | 1 | High in the last cycle of each access beat |
| busOe | output | 1 | Enable for the external bus drivers |
| refReq | input | 1 | Refresh request from the refresh timer |
| refGnt | output | 1 | Refresh grant |
| extReq | input | 1 | External bus-master request |
| busAck | output | 1 | External bus-master acknowledge |
| regWe | input | 1 | Control register write strobe |
| regWdata | input | CTRL_W | Control register write data |
| regRdata | output | CTRL_W | Control register contents |

## Verification
The access timing is swept over all eight wait settings, each with a single beat and a burst. Beat count, driver-enable length and strobe spacing are compared with products computed in the bench, which separates an off-by-one in beat length from a wrong beat count. Requests are raised together to expose the priority order. A manual reset is dropped in right after the second burst beat, to tell a clean beat-boundary cutoff from an immediate abort or a full burst. The first grant is counted edge by edge after each kind of reset, which separates a startup counter that survives manual reset from one that restarts.

// File: rtl/busGatePkg.sv
package busGatePkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ACC   = 3'd1,
    ST_HOLD  = 3'd2,
    ST_REF   = 3'd3,
    ST_EXT   = 3'd4,
    ST_MWAIT = 3'd5
  } gateState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic startAcc;
    logic runBeat;
  } dpCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic beatEnd;
    logic lastBeat;
    logic gateOpen;
    logic mrst;
  } dpStat_t;

endpackage

// File: rtl/busGateDp.sv
module busGateDp
  import busGatePkg::*;
#(
  parameter int CTRL_W      = 8,
  parameter int WAIT_W      = 3,
  parameter int BURST_BEATS = 4,
  parameter int START_CNT_W = 7,
  parameter int CTRL_RST    = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              manRstN,
  input  logic              regWe,
  input  logic [CTRL_W-1:0] regWdata,
  output logic [CTRL_W-1:0] regRdata,
  input  logic              accBurst,
  input  dpCmd_t            cmd,
  output dpStat_t           stat,
  output logic              rstInt
);

  localparam int BEAT_W    = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;
  localparam int START_MAX = (1 << START_CNT_W) - 1;

  logic [1:0]             porSync;
  logic [1:0]             manSync;
  logic [START_CNT_W-1:0] startCnt;
  logic [CTRL_W-1:0]      ctrlReg;
  logic [WAIT_W-1:0]      waitLat;
  logic [WAIT_W-1:0]      cycCnt;
  logic [BEAT_W-1:0]      beatNum;
  logic                   burstLat;
  logic                   gateOpen;
  logic                   beatEnd;

  // power-on reset: asserts at once, releases on the clock
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) porSync <= 2'b00;
    else       porSync <= {porSync[0], 1'b1};
  end
  assign rstInt = ~porSync[1];

  // manual reset: two-flop synchronizer
  always_ff @(posedge clk or posedge rstInt) begin
    if (rstInt) manSync <= 2'b11;
    else        manSync <= {manSync[0], manRstN};
  end

  // hidden startup counter, saturating, cleared by power-on only
  assign gateOpen = (startCnt == START_CNT_W'(START_MAX));
  always_ff @(posedge clk or posedge rstInt) begin
    if (rstInt)         startCnt <= '0;
    else if (!gateOpen) startCnt <= startCnt + 1'b1;
  end

  // control register, loaded only by power-on reset
  always_ff @(posedge clk or posedge rstInt) begin
    if (rstInt)     ctrlReg <= CTRL_W'(CTRL_RST);
    else if (regWe) ctrlReg <= regWdata;
  end
  assign regRdata = ctrlReg;

  // beat timing
  assign beatEnd = (cycCnt == waitLat);
  always_ff @(posedge clk or posedge rstInt) begin
    if (rstInt) begin
      waitLat  <= '0;
      cycCnt   <= '0;
      beatNum  <= '0;
      burstLat <= 1'b0;
    end else if (cmd.startAcc) begin
      waitLat  <= ctrlReg[WAIT_W-1:0];
      burstLat <= accBurst;
      cycCnt   <= '0;
      beatNum  <= '0;
    end else if (cmd.runBeat) begin
      if (beatEnd) begin
        cycCnt  <= '0;
        beatNum <= beatNum + 1'b1;
      end else begin
        cycCnt  <= cycCnt + 1'b1;
      end
    end
  end

  assign stat.beatEnd  = beatEnd;
  assign stat.lastBeat = burstLat ? (beatNum == BEAT_W'(BURST_BEATS - 1)) : (beatNum == '0);
  assign stat.gateOpen = gateOpen;
  assign stat.mrst     = ~manSync[1];

  AST_GATE_STAYS_OPEN: assert property (@(posedge clk) disable iff (rstInt)
    gateOpen |=> gateOpen); // R4

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (rstInt)
    !regWe |=> $stable(ctrlReg)); // R2

  AST_CYC_IN_RANGE: assert property (@(posedge clk) disable iff (rstInt)
    cmd.runBeat |-> (cycCnt <= waitLat)); // R5

endmodule

// File: rtl/busGateCtrl.sv
module busGateCtrl
  import busGatePkg::*;
(
  input  logic    clk,
  input  logic    rstInt,
  input  logic    accReq,
  input  logic    refReq,
  input  logic    extReq,
  input  dpStat_t stat,
  output dpCmd_t  cmd,
  output logic    accGnt,
  output logic    refGnt,
  output logic    busAck,
  output logic    busOe,
  output logic    beatStb
);

  gateState_e state, stateNxt;

  always_ff @(posedge clk or posedge rstInt) begin
    if (rstInt) state <= ST_IDLE;
    else        state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (refReq)                         stateNxt = ST_REF;
        else if (stat.mrst)                 stateNxt = ST_MWAIT;
        else if (accReq && stat.gateOpen)   stateNxt = ST_ACC;
        else if (extReq)                    stateNxt = ST_EXT;
      end
      ST_ACC: begin
        if (stat.beatEnd) begin
          if (stat.mrst)          stateNxt = ST_MWAIT;
          else if (stat.lastBeat) stateNxt = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (stat.mrst)    stateNxt = ST_MWAIT;
        else if (!accReq) stateNxt = ST_IDLE;
      end
      ST_REF:   if (!refReq) stateNxt = ST_IDLE;
      ST_EXT:   if (!extReq) stateNxt = ST_IDLE;
      ST_MWAIT: begin
        if (refReq)          stateNxt = ST_REF;
        else if (!stat.mrst) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign cmd.startAcc = (state == ST_IDLE) && !refReq && !stat.mrst && accReq && stat.gateOpen;
  assign cmd.runBeat  = (state == ST_ACC);

  assign accGnt  = (state == ST_ACC) || (state == ST_HOLD);
  assign refGnt  = (state == ST_REF);
  assign busAck  = (state == ST_EXT);
  assign busOe   = (state == ST_ACC) || (state == ST_REF);
  assign beatStb = (state == ST_ACC) && stat.beatEnd;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rstInt)
    $onehot0({accGnt, refGnt, busAck})); // R10

  AST_REF_FIRST: assert property (@(posedge clk) disable iff (rstInt)
    (state == ST_IDLE && refReq) |=> refGnt); // R10

  AST_ACC_GATED: assert property (@(posedge clk) disable iff (rstInt)
    $rose(accGnt) |-> stat.gateOpen); // R3

  AST_HOLD_GNT: assert property (@(posedge clk) disable iff (rstInt)
    (accGnt && accReq && !stat.mrst) |=> accGnt); // R6

  AST_MRST_CUT: assert property (@(posedge clk) disable iff (rstInt)
    (beatStb && stat.mrst) |=> (!accGnt && !busOe)); // R7

  AST_NO_ACK_MRST: assert property (@(posedge clk) disable iff (rstInt)
    $rose(busAck) |-> $past(!stat.mrst)); // R9

  AST_OE_OFF_EXT: assert property (@(posedge clk) disable iff (rstInt)
    busAck |-> !busOe); // R9

endmodule

// File: rtl/busResetGate.sv
module busResetGate
  import busGatePkg::*;
#(
  parameter int CTRL_W      = 8,
  parameter int WAIT_W      = 3,
  parameter int BURST_BEATS = 4,
  parameter int START_CNT_W = 7,
  parameter int CTRL_RST    = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              manRstN,
  input  logic              accReq,
  input  logic              accBurst,
  output logic              accGnt,
  output logic              beatStb,
  output logic              busOe,
  input  logic              refReq,
  output logic              refGnt,
  input  logic              extReq,
  output logic              busAck,
  input  logic              regWe,
  input  logic [CTRL_W-1:0] regWdata,
  output logic [CTRL_W-1:0] regRdata
);

  dpCmd_t  cmd;
  dpStat_t stat;
  logic    rstInt;

  busGateDp #(
    .CTRL_W(CTRL_W), .WAIT_W(WAIT_W), .BURST_BEATS(BURST_BEATS),
    .START_CNT_W(START_CNT_W), .CTRL_RST(CTRL_RST)
  ) uDp (
    .clk(clk), .porN(porN), .manRstN(manRstN),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .accBurst(accBurst), .cmd(cmd), .stat(stat), .rstInt(rstInt)
  );

  busGateCtrl uCtrl (
    .clk(clk), .rstInt(rstInt),
    .accReq(accReq), .refReq(refReq), .extReq(extReq),
    .stat(stat), .cmd(cmd),
    .accGnt(accGnt), .refGnt(refGnt), .busAck(busAck),
    .busOe(busOe), .beatStb(beatStb)
  );

endmodule

// File: tb/sim_busResetGate.sv
module sim_busResetGate;

  logic       clk = 1'b0;
  logic       porN = 1'b0, manRstN = 1'b1;
  logic       accReq = 1'b0, accBurst = 1'b0, refReq = 1'b0, extReq = 1'b0;
  logic       regWe = 1'b0;
  logic [7:0] regWdata = '0;
  logic       accGnt, beatStb, busOe, refGnt, busAck;
  logic [7:0] regRdata;

  int nChecks = 0;
  int nFail   = 0;

  always #5 clk = ~clk;

  busResetGate u0 (
    .clk(clk), .porN(porN), .manRstN(manRstN),
    .accReq(accReq), .accBurst(accBurst), .accGnt(accGnt),
    .beatStb(beatStb), .busOe(busOe),
    .refReq(refReq), .refGnt(refGnt),
    .extReq(extReq), .busAck(busAck),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [7:0] v);
    regWe = 1'b1; regWdata = v;
    tick();
    regWe = 1'b0;
  endtask

  // one access with wait setting w; counts beats and driver cycles
  task automatic runAccess(input int w, input logic burst);
    int beats = 0, oeCnt = 0, badSpace = 0, expBeats;
    expBeats = burst ? 4 : 1;
    writeReg(8'(w));
    accBurst = burst;
    accReq = 1'b1;
    for (int i = 0; i < 60; i++) begin
      tick();
      if (busOe) oeCnt++;
      if (beatStb) begin
        beats++;
        if ((oeCnt % (w + 1)) != 0) badSpace++;
      end
      if (accGnt && !busOe && oeCnt > 0) break;
    end
    chk($sformatf("R5 beats w=%0d b=%0d", w, burst), beats, expBeats);
    chk($sformatf("R5 oeCycles w=%0d b=%0d", w, burst), oeCnt, expBeats * (w + 1));
    chk($sformatf("R5 strobe spacing w=%0d b=%0d", w, burst), badSpace, 0);
    tick(); tick();
    chk("R6 grant held", int'(accGnt), 1);
    accReq = 1'b0;
    tick();
    chk("R6 grant released", int'(accGnt), 0);
  endtask

  initial begin
    #1500000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int early;
    int beats;
    // power-on reset held
    tick(); tick(); tick();
    chk("R1 reset busOe", int'(busOe), 0);
    chk("R1 reset grants", int'({accGnt, refGnt, busAck, beatStb}), 0);
    chk("R2 reset reg", int'(regRdata), 2);

    // R3 startup gate, request held from release
    accReq = 1'b1;
    porN = 1'b1;
    early = 0;
    for (int k = 1; k <= 130; k++) begin
      tick();
      if (k < 130 && accGnt) early++;
      if (k == 129) chk("R3 no grant at edge 129", int'(accGnt), 0);
      if (k == 130) chk("R3 grant at edge 130", int'(accGnt), 1);
    end
    chk("R3 no early grant", early, 0);
    accReq = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (!accGnt) break;
      tick();
    end
    tick();

    // R5/R6 sweep
    for (int w = 0; w < 8; w++) begin
      runAccess(w, 1'b0);
      runAccess(w, 1'b1);
    end

    // R10 priority
    refReq = 1'b1; accReq = 1'b1; extReq = 1'b1; accBurst = 1'b0;
    tick();
    chk("R10 refresh first", int'({refGnt, accGnt, busAck}), 4);
    chk("R10 busOe in refresh", int'(busOe), 1);
    refReq = 1'b0;
    tick(); tick();
    chk("R10 access second", int'({refGnt, accGnt, busAck}), 2);
    accReq = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (!accGnt) break;
      tick();
    end
    tick();
    chk("R9 ext acked when idle", int'(busAck), 1);
    chk("R9 busOe off while acked", int'(busOe), 0);
    extReq = 1'b0;
    tick();
    chk("R9 ext released", int'(busAck), 0);

    // R7 manual reset cuts burst after the beat in progress
    writeReg(8'hFA);
    accBurst = 1'b1; accReq = 1'b1;
    beats = 0;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (beatStb) begin
        beats++;
        if (beats == 2) manRstN = 1'b0;
      end
      if (i > 2 && !accGnt) break;
    end
    chk("R7 beats after cut", beats, 3);
    chk("R7 busOe off", int'(busOe), 0);
    tick(); tick(); tick();
    chk("R7 no grant during manual reset", int'(accGnt), 0);
    chk("R2 reg kept over manual reset", int'(regRdata), 32'hFA);

    // R8 refresh during manual reset
    refReq = 1'b1;
    tick();
    chk("R8 refresh granted in manual reset", int'(refGnt), 1);
    refReq = 1'b0;
    tick(); tick();
    accReq = 1'b0;
    extReq = 1'b1;
    early = 0;
    for (int i = 0; i < 4; i++) begin
      tick();
      if (busAck) early++;
    end
    chk("R9 no ack in manual reset", early, 0);
    extReq = 1'b0;

    // R4 startup counter survives manual reset
    manRstN = 1'b1; accReq = 1'b1;
    tick(); tick(); tick();
    chk("R4 no grant at edge 3", int'(accGnt), 0);
    tick();
    chk("R4 grant at edge 4", int'(accGnt), 1);
    tick();

    // R1 asynchronous power-on reset mid access
    porN = 1'b0;
    #1;
    chk("R1 async busOe", int'(busOe), 0);
    chk("R1 async grants", int'({accGnt, refGnt, busAck, beatStb}), 0);
    chk("R2 reg reloaded", int'(regRdata), 2);
    @(negedge clk);
    tick();
    porN = 1'b1;
    for (int i = 0; i < 10; i++) tick();
    chk("R3 gate closed after second power-on", int'(accGnt), 0);
    accReq = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule